// File: doc/BRIEF.md
# Lane-Chained Vector Carry Adder

This block adds or subtracts two 128-bit vectors that are split into four 32-bit lanes. The lanes are linked: the carry leaving one lane enters the next one. Lane 0 (bits 31:0) is the least significant link of the chain, and lane 3 (bits 127:96) produces the final carry. A carry flag is stored inside the block. An instruction can take its initial carry from this flag, or it can force the initial carry to 1. Every accepted instruction writes the carry out of lane 3 back into the flag. A chain of additions can therefore extend arithmetic past 128 bits, one instruction after another.

A small decoder inside the block recognises the four instruction encodings from a 32-bit instruction word. The result, the new flag value and a one-cycle valid pulse are registered one cycle after the instruction is accepted. A word that does not match the encoding is ignored, and so is a cycle with the strobe low. Neither one touches the stored state.

Top module: `lane_carry_vec`

## Requirements
- R1: After reset, `resultOut` is 0, `carryFlag` is 0 and `resultValid` is 0.
- R2: For an accepted add (instruction bit 28 = 0), `resultOut` is A + B + cin, taken modulo 2^128, where lane 0 (bits 31:0) is least significant and each lane's carry enters the next lane.
- R3: For an accepted subtract (instruction bit 28 = 1), `resultOut` is A + ~B + cin, taken modulo 2^128. A carry of 1 therefore means no borrow, and equal operands with cin = 1 give zero with a carry of 1.
- R4: When instruction bit 12 = 0, cin is the stored `carryFlag` value from before the instruction.
- R5: When instruction bit 12 = 1, cin is the constant 1, whatever the flag holds.
- R6: After an accepted instruction, `carryFlag` holds the carry out of lane 3 (bits 127:96).
- R7: `resultOut`, `carryFlag` and `resultValid` = 1 appear on the clock edge that samples `inValid` = 1 with a matching word, which is a latency of one cycle. In any other cycle, `resultValid` is 0 after the edge.
- R8: A word is accepted only if (`instrWord` & 32'hEFB1_0F51) == 32'hEE30_0F00, with bits 28 and 12 free. For a non-matching word with `inValid` = 1, `resultOut` and `carryFlag` keep their values and `resultValid` is 0.
- R9: While `inValid` = 0, `resultOut` and `carryFlag` keep their values, even when the word matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: instruction word and operands are valid this cycle |
| instrWord | input | 32 | Instruction word (operation in bit 28, carry source in bit 12) |
| opA | input | 128 | First operand vector, lane 0 in bits 31:0 |
| opB | input | 128 | Second operand vector, lane 0 in bits 31:0 |
| resultOut | output | 128 | Registered result vector |
| carryFlag | output | 1 | Stored carry flag, carry out of lane 3 after the last accepted instruction |
| resultValid | output | 1 | One-cycle pulse after an accepted instruction |

## Verification
The bench builds the block with its default parameters: four lanes of 32 bits. With that shape, one plain 129-bit sum in the reference model predicts every lane boundary. The operands are chosen so that a carry or borrow ripples through all three inter-lane boundaries at once and ends as a carry out of lane 3. Later flag-sourced instructions then consume that carry. Random operands and opcodes, mixed with corrupted words and idle strobes, check that the stored flag persists correctly across long sequences.

// File: rtl/lane_carry_pkg.sv
package lane_carry_pkg;
  // Fixed-bit pattern of the four accepted encodings; bits 28 and 12 are free.
  localparam logic [31:0] ENC_MASK  = 32'hEFB1_0F51;
  localparam logic [31:0] ENC_VALUE = 32'hEE30_0F00;
  localparam int unsigned SUB_BIT   = 28;
  localparam int unsigned CONST_BIT = 12;

  typedef struct packed {
    logic accept;      // load result, flag and valid pulse
    logic doSub;       // invert second operand
    logic constCarry;  // initial carry forced to 1
  } ctrlStrobes_t;
endpackage

// File: rtl/lane_carry_ctrl.sv
module lane_carry_ctrl
  import lane_carry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [31:0]  instrWord,
  output ctrlStrobes_t strobes
);
  logic encHit;

  always_comb begin
    encHit             = ((instrWord & ENC_MASK) == ENC_VALUE);
    strobes.accept     = inValid && encHit;
    strobes.doSub      = instrWord[SUB_BIT];
    strobes.constCarry = instrWord[CONST_BIT];
  end

  // An accept strobe never appears without the input strobe.
  assert_strobe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |-> inValid);
endmodule

// File: rtl/lane_carry_dp.sv
module lane_carry_dp
  import lane_carry_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [LANE_W*LANES-1:0]  opA,
  input  logic [LANE_W*LANES-1:0]  opB,
  output logic [LANE_W*LANES-1:0]  resultOut,
  output logic                     carryFlag,
  output logic                     resultValid
);
  localparam int unsigned VEC_W = LANE_W * LANES;
  localparam int unsigned EXT_W = LANE_W + 1;

  logic [LANES:0]     chainC;
  logic [VEC_W-1:0]   sumVec;
  logic [VEC_W-1:0]   resultQ;
  logic               flagQ;
  logic               validQ;

  assign chainC[0] = strobes.constCarry ? 1'b1 : flagQ;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANE_W-1:0] aLane;
    logic [LANE_W-1:0] bLane;
    logic [EXT_W-1:0]  laneSum;
    assign aLane   = opA[gi*LANE_W +: LANE_W];
    assign bLane   = strobes.doSub ? ~opB[gi*LANE_W +: LANE_W] : opB[gi*LANE_W +: LANE_W];
    assign laneSum = {1'b0, aLane} + {1'b0, bLane} + EXT_W'(chainC[gi]);
    assign sumVec[gi*LANE_W +: LANE_W] = laneSum[LANE_W-1:0];
    assign chainC[gi+1] = laneSum[LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagQ   <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobes.accept;
      if (strobes.accept) begin
        resultQ <= sumVec;
        flagQ   <= chainC[LANES];
      end
    end
  end

  assign resultOut   = resultQ;
  assign carryFlag   = flagQ;
  assign resultValid = validQ;

  // Without an accept the stored state is frozen.
  assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accept |=> ($stable(resultOut) && $stable(carryFlag) && !resultValid));

  // Accept produces the valid pulse on the next edge.
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> resultValid);

  // Subtracting equal operands with constant carry gives zero and no borrow.
  assert_equal_sub_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && strobes.doSub && strobes.constCarry && opA == opB)
      |=> (resultOut == '0 && carryFlag));

  // Adding zero with constant carry increments the first operand.
  assert_increment_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && !strobes.doSub && strobes.constCarry && opB == '0 && opA != '1)
      |=> (resultOut == $past(opA) + VEC_W'(1) && !carryFlag));
endmodule

// File: rtl/lane_carry_vec.sv
module lane_carry_vec
  import lane_carry_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [31:0]             instrWord,
  input  logic [LANE_W*LANES-1:0] opA,
  input  logic [LANE_W*LANES-1:0] opB,
  output logic [LANE_W*LANES-1:0] resultOut,
  output logic                    carryFlag,
  output logic                    resultValid
);
  ctrlStrobes_t strobes;

  lane_carry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .instrWord (instrWord),
    .strobes   (strobes)
  );

  lane_carry_dp #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .opA         (opA),
    .opB         (opB),
    .resultOut   (resultOut),
    .carryFlag   (carryFlag),
    .resultValid (resultValid)
  );
endmodule

// File: tb/lane_carry_vec_bench.sv
module lane_carry_vec_bench;
  localparam logic [31:0] W_ADC  = 32'hEE30_0F00;
  localparam logic [31:0] W_SBC  = 32'hFE30_0F00;
  localparam logic [31:0] W_ADCI = 32'hEE30_1F00;
  localparam logic [31:0] W_SBCI = 32'hFE30_1F00;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [127:0] resultOut;
  logic         carryFlag;
  logic         resultValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [127:0] expResult = '0;
  logic         expFlag = 1'b0;
  logic         expValid = 1'b0;
  string        pendTag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  lane_carry_vec u_lane_carry_vec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .opA(opA), .opB(opB), .resultOut(resultOut), .carryFlag(carryFlag),
    .resultValid(resultValid)
  );

  task automatic compareNow(input string tag);
    checks++;
    if (resultOut !== expResult || carryFlag !== expFlag || resultValid !== expValid) begin
      failures++;
      $display("FAIL %s: result=%h flag=%b valid=%b expected result=%h flag=%b valid=%b",
               tag, resultOut, carryFlag, resultValid, expResult, expFlag, expValid);
    end
  endtask

  // Check the state from the previous edge, then drive new stimulus and predict.
  task automatic step(input logic v, input logic [31:0] w,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [128:0] wide;
    logic         cin;
    logic         hit;
    @(negedge clk);
    compareNow(pendTag);
    inValid = v; instrWord = w; opA = a; opB = b;
    hit = v && ((w & 32'hEFB1_0F51) == 32'hEE30_0F00);
    if (hit) begin
      cin  = w[12] ? 1'b1 : expFlag;
      wide = {1'b0, a} + {1'b0, (w[28] ? ~b : b)} + 129'(cin);
      expResult = wide[127:0];
      expFlag   = wide[128];
    end
    expValid = hit;
    pendTag  = tag;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compareNow("R1 in reset");
    rstN = 1'b1;
    // R1: state right after reset release
    step(1'b0, W_ADC, '0, '0, "R1");
    // R2 R5: plain add with constant carry
    step(1'b1, W_ADCI, 128'h5, 128'h7, "R2 R5 small add");
    // R2 R6: ripple through all lane boundaries, carry out of lane 3
    step(1'b1, W_ADCI, {128{1'b1}}, '0, "R2 R6 full ripple");
    // R4: flag (1) is consumed as initial carry
    step(1'b1, W_ADC, 128'h0000_0001_FFFF_FFFF_0000_0000_FFFF_FFFF, 128'h1, "R4 flag carry in");
    // R4: flag now 0
    step(1'b1, W_ADC, 128'h10, 128'h20, "R4 flag zero carry in");
    // R3 R5: equal operands, constant carry -> 0 and no borrow
    step(1'b1, W_SBCI, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F0F_F0F0,
         128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F0F_F0F0, "R3 R5 equal subtract");
    // R3: borrow through every lane
    step(1'b1, W_SBCI, '0, 128'h1, "R3 R6 borrow ripple");
    // R4 R3: flag 0 -> subtract with extra borrow
    step(1'b1, W_SBC, 128'h100, 128'h1, "R3 R4 flag borrow");
    // R8: bit 4 set breaks the pattern
    step(1'b1, W_ADCI | 32'h10, rnd128(), rnd128(), "R8 decode miss bit4");
    // R8: bit 24 set breaks the pattern
    step(1'b1, W_SBC | 32'h0100_0000, rnd128(), rnd128(), "R8 decode miss bit24");
    // R9: strobe low with matching word
    step(1'b0, W_ADCI, rnd128(), rnd128(), "R9 strobe low");
    // R7: back-to-back accepts
    step(1'b1, W_ADCI, 128'hFFFF_FFFF, 128'h1, "R7 back to back a");
    step(1'b1, W_ADC, 128'hFFFF_FFFF_0000_0000, 128'h1_0000_0000, "R7 back to back b");
    // Random mix; R10-free free bits 22/7 toggled too
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      logic [31:0] pick;
      pick = $urandom % 4;
      case (pick)
        0: w = W_ADC; 1: w = W_SBC; 2: w = W_ADCI; default: w = W_SBCI;
      endcase
      w = w | ($urandom & 32'h004E_E0AE);
      if (($urandom % 8) == 0) w = w ^ 32'h0000_0040;
      if (($urandom % 6) == 0) begin
        step(1'b1, w, (($urandom % 2) != 0) ? {128{1'b1}} : rnd128(), rnd128(), "R2 R3 R6 R8 random");
      end else begin
        step(($urandom % 5) != 0, w, rnd128(), rnd128(), "R2 R3 R4 R9 random");
      end
    end
    step(1'b0, W_ADC, '0, '0, "R7 final");
    @(negedge clk);
    compareNow(pendTag);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule